// File: doc/BRIEF.md
# Branch Confidence Estimator

This block rates each branch prediction of a multi-context core with a confidence value. It then reduces that value to a single high/low bit for fetch gating. When the bit is low, fetch for the thread stalls until the branch resolves. When it is high, fetch follows the prediction. Three estimators sit behind one lookup port and one update port, and a mode input picks which one drives the output:

- a table of saturating counters, indexed by a hash of the branch address and the global history;
- a count of how many of the two component predictor counters are saturated;
- a per-context run length of consecutive correct predictions.

A lookup is combinational. It returns the confidence value, the high/low decision and the table index used. The core keeps that index with the branch and returns it, together with the context and the outcome, on the update port when the branch resolves. Both trained estimators, the table and the run-length counters, learn from every update whatever the selected mode. The mode can therefore change without a warm-up period.

Top module: `branch_conf_est`

## Requirements
- R1: The table index is `pc[9:0] ^ pc[15:10] ^ hist` (upper PC bits zero-extended) and appears on `lk_idx_o`. Two lookups with equal index read the same counter.
- R2: A correct update increments the 4-bit table counter at `up_idx_i`, saturating at 15.
- R3: An incorrect update clears the table counter at `up_idx_i` to 0.
- R4: In mode 1 the confidence is the number of the two 2-bit predictor counters that equal 0 or 3 (0, 1 or 2).
- R5: In mode 2 the confidence is the number of consecutive correct updates of the lookup context, over all of its branches. Other contexts are unaffected.
- R6: An incorrect update clears the run count of its context. Run counts saturate at 15.
- R7: `high_conf_o` is 1 exactly when the confidence is greater than or equal to `thresh_i`.
- R8: After reset every table counter and every run count is 0.
- R9: An update in the same cycle as a lookup of the same entry changes the value only from the next cycle. The lookup sees the old value.
- R10: Mode encoding: 0 table, 1 strong count, 2 run length. Mode 3 gives confidence 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Estimator select |
| thresh_i | input | 4 | High-confidence threshold |
| lk_pc_i | input | 16 | Lookup branch address |
| lk_hist_i | input | 10 | Lookup global history |
| lk_ctx_i | input | 3 | Lookup context |
| lk_local_ctr_i | input | 2 | Local predictor counter state |
| lk_global_ctr_i | input | 2 | Global predictor counter state |
| up_valid_i | input | 1 | Update strobe |
| up_ctx_i | input | 3 | Resolving branch context |
| up_idx_i | input | 10 | Table index saved at lookup |
| up_correct_i | input | 1 | Prediction was correct |
| conf_o | output | 4 | Confidence value |
| high_conf_o | output | 1 | Confidence at or above threshold |
| lk_idx_o | output | 10 | Table index of the lookup |

## Verification
The bench drives the table counter past 15 and the run count past 15. A design that wraps instead of saturating would return a small value and drop the high bit at threshold 15. It places a lookup and an update to the same entry in one cycle. A design that forwards the update would report the incremented value one cycle early. It interleaves updates of two contexts and aliases two address/history pairs onto one index. These catch a run count kept per branch rather than per context, and a hash that ignores the upper address bits. The threshold is swept across each value boundary, so an off-by-one compare shows as a wrong decision at equality.

// File: rtl/branch_conf_pkg.sv
package branch_conf_pkg;
  typedef enum logic [1:0] {
    MODE_TABLE  = 2'd0,
    MODE_STRONG = 2'd1,
    MODE_DIST   = 2'd2,
    MODE_OFF    = 2'd3
  } conf_mode_e;
endpackage

// File: rtl/conf_table.sv
module conf_table #(
  parameter int IDX_W  = 10,
  parameter int CONF_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [CONF_W-1:0] rd_val_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_hit_i
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CONF_W-1:0] MAX = '1;

  logic [CONF_W-1:0] ctr_q [DEPTH];

  // read returns stored value; same-cycle write lands at the edge
  assign rd_val_o = ctr_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= '0;
    end else if (wr_en_i) begin
      if (!wr_hit_i)                  ctr_q[wr_idx_i] <= '0;
      else if (ctr_q[wr_idx_i] != MAX) ctr_q[wr_idx_i] <= ctr_q[wr_idx_i] + 1'b1;
    end
  end
endmodule

// File: rtl/conf_distance.sv
module conf_distance #(
  parameter int CTX_N  = 8,
  parameter int CONF_W = 4,
  localparam int CTX_W = $clog2(CTX_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTX_W-1:0]  rd_ctx_i,
  output logic [CONF_W-1:0] rd_val_o,
  input  logic              wr_en_i,
  input  logic [CTX_W-1:0]  wr_ctx_i,
  input  logic              wr_hit_i
);
  localparam logic [CONF_W-1:0] MAX = '1;

  logic [CONF_W-1:0] run_q [CTX_N];

  assign rd_val_o = run_q[rd_ctx_i];

  for (genvar c = 0; c < CTX_N; c++) begin : g_ctx
    logic sel;
    assign sel = wr_en_i && (wr_ctx_i == CTX_W'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  run_q[c] <= '0;
      else if (sel && !wr_hit_i)    run_q[c] <= '0;
      else if (sel && run_q[c] != MAX) run_q[c] <= run_q[c] + 1'b1;
    end
  end
endmodule

// File: rtl/conf_strong.sv
module conf_strong #(
  parameter int PRED_W = 2
) (
  input  logic [PRED_W-1:0] local_ctr_i,
  input  logic [PRED_W-1:0] global_ctr_i,
  output logic [1:0]        count_o
);
  logic loc_sat, glb_sat;
  assign loc_sat = (local_ctr_i == '0) || (local_ctr_i == '1);
  assign glb_sat = (global_ctr_i == '0) || (global_ctr_i == '1);
  assign count_o = {1'b0, loc_sat} + {1'b0, glb_sat};
endmodule

// File: rtl/branch_conf_est.sv
module branch_conf_est
  import branch_conf_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int IDX_W  = 10,
  parameter int CTX_N  = 8,
  parameter int CONF_W = 4,
  parameter int PRED_W = 2,
  localparam int CTX_W = $clog2(CTX_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [CONF_W-1:0] thresh_i,
  input  logic [PC_W-1:0]   lk_pc_i,
  input  logic [IDX_W-1:0]  lk_hist_i,
  input  logic [CTX_W-1:0]  lk_ctx_i,
  input  logic [PRED_W-1:0] lk_local_ctr_i,
  input  logic [PRED_W-1:0] lk_global_ctr_i,
  input  logic              up_valid_i,
  input  logic [CTX_W-1:0]  up_ctx_i,
  input  logic [IDX_W-1:0]  up_idx_i,
  input  logic              up_correct_i,
  output logic [CONF_W-1:0] conf_o,
  output logic              high_conf_o,
  output logic [IDX_W-1:0]  lk_idx_o
);
  localparam int EXT_W = 2 * IDX_W;

  logic [EXT_W-1:0]  pc_ext;
  logic [CONF_W-1:0] tbl_val, dist_val;
  logic [1:0]        strong_cnt;

  // fold address into index width, then mix history
  assign pc_ext   = EXT_W'(lk_pc_i);
  assign lk_idx_o = pc_ext[IDX_W-1:0] ^ pc_ext[EXT_W-1:IDX_W] ^ lk_hist_i;

  conf_table #(.IDX_W(IDX_W), .CONF_W(CONF_W)) u_table (
    .clk_i, .rst_ni,
    .rd_idx_i(lk_idx_o), .rd_val_o(tbl_val),
    .wr_en_i(up_valid_i), .wr_idx_i(up_idx_i), .wr_hit_i(up_correct_i)
  );

  conf_distance #(.CTX_N(CTX_N), .CONF_W(CONF_W)) u_dist (
    .clk_i, .rst_ni,
    .rd_ctx_i(lk_ctx_i), .rd_val_o(dist_val),
    .wr_en_i(up_valid_i), .wr_ctx_i(up_ctx_i), .wr_hit_i(up_correct_i)
  );

  conf_strong #(.PRED_W(PRED_W)) u_strong (
    .local_ctr_i(lk_local_ctr_i), .global_ctr_i(lk_global_ctr_i), .count_o(strong_cnt)
  );

  always_comb begin
    unique case (conf_mode_e'(mode_i))
      MODE_TABLE:  conf_o = tbl_val;
      MODE_STRONG: conf_o = CONF_W'(strong_cnt);
      MODE_DIST:   conf_o = dist_val;
      default:     conf_o = '0;
    endcase
  end

  assign high_conf_o = (conf_o >= thresh_i);
endmodule

// File: rtl/branch_conf_est_chk.sv
module branch_conf_est_chk #(
  parameter int IDX_W  = 10,
  parameter int CONF_W = 4,
  parameter int CTX_W  = 3,
  parameter int PRED_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic [CONF_W-1:0] thresh_i,
  input logic [CTX_W-1:0]  lk_ctx_i,
  input logic [PRED_W-1:0] lk_local_ctr_i,
  input logic [PRED_W-1:0] lk_global_ctr_i,
  input logic              up_valid_i,
  input logic [CTX_W-1:0]  up_ctx_i,
  input logic [IDX_W-1:0]  up_idx_i,
  input logic              up_correct_i,
  input logic [CONF_W-1:0] conf_o,
  input logic              high_conf_o,
  input logic [IDX_W-1:0]  lk_idx_o
);
  localparam logic [CONF_W-1:0] MAX = '1;

  assert_tbl_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(up_valid_i && !up_correct_i) && mode_i == 2'd0 && lk_idx_o == $past(up_idx_i))
    |-> conf_o == '0);

  assert_tbl_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(up_valid_i && up_correct_i && mode_i == 2'd0 && lk_idx_o == up_idx_i)
     && mode_i == 2'd0 && $stable(lk_idx_o))
    |-> conf_o == (($past(conf_o) == MAX) ? MAX : $past(conf_o) + 1'b1));

  assert_dist_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(up_valid_i && !up_correct_i) && mode_i == 2'd2 && lk_ctx_i == $past(up_ctx_i))
    |-> conf_o == '0);

  assert_strong_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1) |-> conf_o <= CONF_W'(2));

  assert_strong_both_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && (lk_local_ctr_i == '0 || lk_local_ctr_i == '1)
     && (lk_global_ctr_i == '0 || lk_global_ctr_i == '1) && thresh_i <= CONF_W'(2))
    |-> high_conf_o);

  assert_off_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && thresh_i != '0) |-> !high_conf_o);
endmodule

bind branch_conf_est branch_conf_est_chk #(
  .IDX_W(IDX_W), .CONF_W(CONF_W), .CTX_W(CTX_W), .PRED_W(PRED_W)
) u_chk (
  .clk_i, .rst_ni, .mode_i, .thresh_i, .lk_ctx_i, .lk_local_ctr_i, .lk_global_ctr_i,
  .up_valid_i, .up_ctx_i, .up_idx_i, .up_correct_i, .conf_o, .high_conf_o, .lk_idx_o
);

// File: tb/branch_conf_est_tb.sv
module branch_conf_est_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode;
  logic [3:0]  thresh;
  logic [15:0] pc;
  logic [9:0]  hist;
  logic [2:0]  lctx;
  logic [1:0]  lloc, lglb;
  logic        upv;
  logic [2:0]  uctx;
  logic [9:0]  uidx;
  logic        uok;
  logic [3:0]  conf;
  logic        hi;
  logic [9:0]  idx;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  branch_conf_est u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .thresh_i(thresh),
    .lk_pc_i(pc), .lk_hist_i(hist), .lk_ctx_i(lctx),
    .lk_local_ctr_i(lloc), .lk_global_ctr_i(lglb),
    .up_valid_i(upv), .up_ctx_i(uctx), .up_idx_i(uidx), .up_correct_i(uok),
    .conf_o(conf), .high_conf_o(hi), .lk_idx_o(idx)
  );

  function automatic logic [9:0] hash(input logic [15:0] a, input logic [9:0] h);
    return a[9:0] ^ {4'b0, a[15:10]} ^ h;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic look(input logic [1:0] m, input logic [3:0] t, input logic [15:0] a,
                      input logic [9:0] h, input logic [2:0] c);
    mode = m; thresh = t; pc = a; hist = h; lctx = c;
    #1;
  endtask

  task automatic upd(input logic [2:0] c, input logic [9:0] i, input logic ok);
    upv = 1'b1; uctx = c; uidx = i; uok = ok;
    @(posedge clk); @(negedge clk);
    upv = 1'b0;
  endtask

  task automatic t_reset;
    look(2'd0, 4'd1, 16'h1234, 10'h0aa, 3'd0);
    chk("R8 table", conf, 0);
    chk("R8 high", hi, 0);
    look(2'd2, 4'd1, 16'h1234, 10'h0aa, 3'd5);
    chk("R8 dist", conf, 0);
  endtask

  task automatic t_index;
    logic [9:0] a;
    look(2'd0, 4'd1, 16'hbeef, 10'h155, 3'd0);
    a = hash(16'hbeef, 10'h155);
    chk("R1 index", idx, a);
    upd(3'd0, a, 1'b1);
    upd(3'd0, a, 1'b1);
    // alias: different pc/hist landing on same index
    look(2'd0, 4'd1, 16'h0000, a, 3'd0);
    chk("R1 alias idx", idx, a);
    chk("R1 alias share", conf, 2);
  endtask

  task automatic t_table;
    logic [9:0] a;
    a = hash(16'h4321, 10'h003);
    look(2'd0, 4'd3, 16'h4321, 10'h003, 3'd1);
    for (int k = 0; k < 3; k++) upd(3'd1, a, 1'b1);
    look(2'd0, 4'd3, 16'h4321, 10'h003, 3'd1);
    chk("R2 count3", conf, 3);
    chk("R7 eq thresh", hi, 1);
    look(2'd0, 4'd4, 16'h4321, 10'h003, 3'd1);
    chk("R7 below thresh", hi, 0);
    upd(3'd1, a, 1'b0);
    look(2'd0, 4'd1, 16'h4321, 10'h003, 3'd1);
    chk("R3 cleared", conf, 0);
    for (int k = 0; k < 20; k++) upd(3'd1, a, 1'b1);
    look(2'd0, 4'd15, 16'h4321, 10'h003, 3'd1);
    chk("R2 saturate", conf, 15);
    chk("R7 thr15", hi, 1);
  endtask

  task automatic t_same_cycle;
    logic [9:0] a;
    a = hash(16'h0777, 10'h020);
    look(2'd0, 4'd1, 16'h0777, 10'h020, 3'd0);
    upv = 1'b1; uctx = 3'd0; uidx = a; uok = 1'b1;
    #1;
    chk("R9 old value", conf, 0);
    @(posedge clk); @(negedge clk);
    upv = 1'b0;
    #1;
    chk("R9 after edge", conf, 1);
  endtask

  task automatic t_strong;
    look(2'd1, 4'd2, 16'h0, 10'h0, 3'd0);
    lloc = 2'd0; lglb = 2'd3; #1;
    chk("R4 both", conf, 2);
    chk("R7 strong thr2", hi, 1);
    lloc = 2'd1; lglb = 2'd2; #1;
    chk("R4 none", conf, 0);
    lloc = 2'd3; lglb = 2'd1; #1;
    chk("R4 one", conf, 1);
    chk("R7 one<2", hi, 0);
    thresh = 4'd1; #1;
    chk("R7 one>=1", hi, 1);
  endtask

  task automatic t_dist;
    look(2'd2, 4'd7, 16'h0, 10'h0, 3'd2);
    for (int k = 0; k < 5; k++) upd(3'd2, 10'(k * 37), 1'b1);
    upd(3'd3, 10'd9, 1'b1);
    upd(3'd2, 10'd11, 1'b1);
    look(2'd2, 4'd7, 16'h0, 10'h0, 3'd2);
    chk("R5 run6", conf, 6);
    chk("R7 6<7", hi, 0);
    upd(3'd2, 10'd12, 1'b1);
    look(2'd2, 4'd7, 16'h0, 10'h0, 3'd2);
    chk("R7 7>=7", hi, 1);
    look(2'd2, 4'd1, 16'h0, 10'h0, 3'd3);
    chk("R5 other ctx", conf, 1);
    upd(3'd2, 10'd1, 1'b0);
    look(2'd2, 4'd1, 16'h0, 10'h0, 3'd2);
    chk("R6 cleared", conf, 0);
    look(2'd2, 4'd1, 16'h0, 10'h0, 3'd3);
    chk("R6 other kept", conf, 1);
    for (int k = 0; k < 18; k++) upd(3'd4, 10'd5, 1'b1);
    look(2'd2, 4'd15, 16'h0, 10'h0, 3'd4);
    chk("R6 saturate", conf, 15);
  endtask

  task automatic t_mode_off;
    look(2'd3, 4'd1, 16'h4321, 10'h003, 3'd4);
    chk("R10 off conf", conf, 0);
    chk("R10 off high", hi, 0);
    look(2'd0, 4'd1, 16'h4321, 10'h003, 3'd4);
    chk("R10 table sel", conf, 15);
  endtask

  initial begin
    mode = 2'd0; thresh = 4'd1; pc = '0; hist = '0; lctx = '0;
    lloc = 2'd1; lglb = 2'd1; upv = 1'b0; uctx = '0; uidx = '0; uok = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index();
    t_table();
    t_same_cycle();
    t_strong();
    t_dist();
    t_mode_off();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule